// File: doc/BRIEF.md
# Multi-Port Shared Register File with Write-Conflict Resolution

A small register file shared by several request ports. In each cycle every port may present one access, a read or a write, and all of them are resolved together in that same cycle. Ports that touch different addresses never interfere. When two or more ports reach the same address, two static mode inputs decide what happens. One input allows or forbids shared reads. The other allows or forbids shared writes. A policy selector then sets the value that a shared write leaves in the location.

Each port receives its read data and a grant or deny flag in the cycle of the request. Writes take effect at the next rising clock edge. A read therefore always sees the contents from before that edge, including a read of a location that is being written in the same cycle. The whole array is also driven out so that its contents can be observed directly.

Top module: `shmem_resolver`

## Requirements
- R1: While reset is asserted, every memory word becomes zero. Directly after reset, with no requests, grant and deny are all zero.
- R2: Requests to pairwise different addresses are all granted in the same cycle. Each written word holds its new value after the next rising edge.
- R3: With shared reads off (`rd_conc`=0), of several ports reading one address only the lowest-numbered one is granted. The others are denied and see zero on their read data.
- R4: With shared reads on (`rd_conc`=1), every port reading one address is granted and receives a copy of the word.
- R5: With shared writes off (`wr_conc`=0), of several ports writing one address only the lowest-numbered one is granted and its value is stored. The others are denied.
- R6: With shared writes on and policy 0 (priority), all colliding writers are granted and the value of the lowest-numbered writer is stored. Policy codes 5 to 7 act as priority.
- R7: With shared writes on and policy 1 (common value), colliding writes are stored and granted only if all their values are equal. Otherwise every one of them is denied and the word keeps its old contents.
- R8: With shared writes on, policy 2 stores the unsigned maximum and policy 3 stores the unsigned minimum of the colliding values. All of those writers are granted.
- R9: With shared writes on and policy 4, the sum of the colliding values is stored, reduced modulo 2^DW.
- R10: A read and a write to the same address in one cycle do not conflict. Both are granted and the read returns the contents from before the write.
- R11: A port with no request has grant and deny at zero and read data of zero. Deny is only ever raised for a port that has a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_conc | input | 1 | 1 allows shared reads of one address |
| wr_conc | input | 1 | 1 allows shared writes to one address |
| wr_policy | input | 3 | Shared-write rule: 0 priority, 1 common, 2 max, 3 min, 4 sum |
| req_vld | input | P | Per-port request present |
| req_we | input | P | Per-port access kind, 1 write, 0 read |
| req_addr | input | P*AW | Per-port address, port i in bits [i*AW +: AW] |
| req_wdata | input | P*DW | Per-port write value, port i in bits [i*DW +: DW] |
| rd_data | output | P*DW | Per-port read data, port i in bits [i*DW +: DW] |
| grant | output | P | Per-port request accepted this cycle |
| deny | output | P | Per-port request refused this cycle |
| mem_q | output | (2^AW)*DW | Full array contents, word a in bits [a*DW +: DW] |

## Verification
A wrong collision match shows up at the ports in the same cycle as the request, as a wrong grant/deny pattern or as zeroed read data. A wrong merge or write enable shows up one edge later, as a wrong word on `mem_q`, and any read of that word afterwards returns it again. A denied common-value write that still changes the word can only be seen after the edge, by comparing the word with its value before the edge.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [2:0] {
    POL_PRIO   = 3'd0,
    POL_COMMON = 3'd1,
    POL_MAX    = 3'd2,
    POL_MIN    = 3'd3,
    POL_SUM    = 3'd4
  } wpol_e;
endpackage

// File: rtl/smr_collide.sv
// Flags, for each port, whether a lower-numbered port makes the same kind
// of access to the same address in this cycle.
module smr_collide #(
  parameter int P  = 4,
  parameter int AW = 3
) (
  input  logic [P-1:0]    rd_req,
  input  logic [P-1:0]    wr_req,
  input  logic [P*AW-1:0] addr,
  output logic [P-1:0]    rd_shadow,
  output logic [P-1:0]    wr_shadow
);
  always_comb begin
    rd_shadow = '0;
    wr_shadow = '0;
    for (int i = 1; i < P; i++) begin
      for (int j = 0; j < i; j++) begin
        if (addr[i*AW +: AW] == addr[j*AW +: AW]) begin
          if (rd_req[i] && rd_req[j]) rd_shadow[i] = 1'b1;
          if (wr_req[i] && wr_req[j]) wr_shadow[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/smr_slot_merge.sv
// Resolves every write aimed at one word into one enable and one value.
module smr_slot_merge
  import smr_pkg::*;
#(
  parameter int P  = 4,
  parameter int DW = 8
) (
  input  logic [P-1:0]    hit,
  input  logic [P*DW-1:0] wdata,
  input  wpol_e           pol,
  output logic            wen,
  output logic [DW-1:0]   wval,
  output logic            agree
);
  function automatic logic [DW-1:0] pick_max(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [DW-1:0] pick_min(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [DW-1:0] wrap_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  logic [DW-1:0] acc;
  logic [DW-1:0] first_v;
  logic          seen;

  // Walk from the highest port down so that in priority mode the
  // lowest-numbered writer is the last one to land in acc.
  always_comb begin
    acc     = '0;
    first_v = '0;
    seen    = 1'b0;
    agree   = 1'b1;
    for (int i = P - 1; i >= 0; i--) begin
      if (hit[i]) begin
        if (!seen) begin
          acc     = wdata[i*DW +: DW];
          first_v = wdata[i*DW +: DW];
          seen    = 1'b1;
        end else begin
          unique case (pol)
            POL_MAX:    acc = pick_max(acc, wdata[i*DW +: DW]);
            POL_MIN:    acc = pick_min(acc, wdata[i*DW +: DW]);
            POL_SUM:    acc = wrap_add(acc, wdata[i*DW +: DW]);
            POL_COMMON: begin
              if (wdata[i*DW +: DW] != first_v) agree = 1'b0;
              acc = wdata[i*DW +: DW];
            end
            default:    acc = wdata[i*DW +: DW];
          endcase
        end
      end
    end
    wen  = seen && ((pol != POL_COMMON) || agree);
    wval = acc;
  end
endmodule

// File: rtl/smr_read_port.sv
// One read path: selects the word at the address, zero when not enabled.
module smr_read_port #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic [(1<<AW)*DW-1:0] mem_flat,
  input  logic [AW-1:0]         addr,
  input  logic                  en,
  output logic [DW-1:0]         data
);
  assign data = en ? mem_flat[addr*DW +: DW] : '0;
endmodule

// File: rtl/shmem_resolver.sv
module shmem_resolver
  import smr_pkg::*;
#(
  parameter int P  = 4,
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_conc,
  input  logic                  wr_conc,
  input  logic [2:0]            wr_policy,
  input  logic [P-1:0]          req_vld,
  input  logic [P-1:0]          req_we,
  input  logic [P*AW-1:0]       req_addr,
  input  logic [P*DW-1:0]       req_wdata,
  output logic [P*DW-1:0]       rd_data,
  output logic [P-1:0]          grant,
  output logic [P-1:0]          deny,
  output logic [(1<<AW)*DW-1:0] mem_q
);
  localparam int DEPTH = 1 << AW;

  logic [P-1:0]        rd_req, wr_req;
  logic [P-1:0]        rd_shadow, wr_shadow;
  logic [P-1:0]        rd_deny_w, wr_deny_w;
  logic [DEPTH-1:0]    slot_wen, slot_agree;
  logic [DEPTH*DW-1:0] slot_val;
  logic [DEPTH*DW-1:0] mem_r;
  wpol_e               eff_pol;

  assign rd_req = req_vld & ~req_we;
  assign wr_req = req_vld & req_we;

  // Exclusive writes resolve like the priority rule; unused codes too.
  always_comb begin
    if (!wr_conc || wr_policy > 3'd4) eff_pol = POL_PRIO;
    else                              eff_pol = wpol_e'(wr_policy);
  end

  smr_collide #(.P(P), .AW(AW)) u_collide (
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .addr      (req_addr),
    .rd_shadow (rd_shadow),
    .wr_shadow (wr_shadow)
  );

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [P-1:0] hit;
    always_comb begin
      for (int i = 0; i < P; i++)
        hit[i] = wr_req[i] && (req_addr[i*AW +: AW] == AW'(s));
    end

    smr_slot_merge #(.P(P), .DW(DW)) u_merge (
      .hit   (hit),
      .wdata (req_wdata),
      .pol   (eff_pol),
      .wen   (slot_wen[s]),
      .wval  (slot_val[s*DW +: DW]),
      .agree (slot_agree[s])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           mem_r[s*DW +: DW] <= '0;
      else if (slot_wen[s]) mem_r[s*DW +: DW] <= slot_val[s*DW +: DW];
    end
  end

  for (genvar i = 0; i < P; i++) begin : g_port
    logic [AW-1:0] a;
    assign a = req_addr[i*AW +: AW];

    assign rd_deny_w[i] = rd_req[i] && !rd_conc && rd_shadow[i];
    assign wr_deny_w[i] = wr_req[i] &&
                          (wr_conc ? ((eff_pol == POL_COMMON) && !slot_agree[a])
                                   : wr_shadow[i]);

    smr_read_port #(.AW(AW), .DW(DW)) u_rd (
      .mem_flat (mem_r),
      .addr     (a),
      .en       (rd_req[i] && !rd_deny_w[i]),
      .data     (rd_data[i*DW +: DW])
    );
  end

  assign deny  = rd_deny_w | wr_deny_w;
  assign grant = req_vld & ~deny;
  assign mem_q = mem_r;
endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
  parameter int P  = 4,
  parameter int AW = 3,
  parameter int DW = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rd_conc,
  input logic                  wr_conc,
  input logic [2:0]            wr_policy,
  input logic [P-1:0]          req_vld,
  input logic [P-1:0]          req_we,
  input logic [P*AW-1:0]       req_addr,
  input logic [P*DW-1:0]       req_wdata,
  input logic [P*DW-1:0]       rd_data,
  input logic [P-1:0]          grant,
  input logic [P-1:0]          deny,
  input logic [(1<<AW)*DW-1:0] mem_q
);
  function automatic logic [DW-1:0] word_at(input logic [(1<<AW)*DW-1:0] m,
                                            input logic [AW-1:0] a);
    return m[a*DW +: DW];
  endfunction

  // R11
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((deny | grant) & ~req_vld) == '0);

  // R5
  port0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld[0] && req_we[0] && (!wr_conc || wr_policy == 3'd0))
    |=> word_at(mem_q, $past(req_addr[0 +: AW])) == $past(req_wdata[0 +: DW]));

  for (genvar i = 0; i < P; i++) begin : g_p
    // R10
    rd_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && !req_we[i])
      |-> rd_data[i*DW +: DW] == word_at(mem_q, req_addr[i*AW +: AW]));

    // R7
    common_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_conc && wr_policy == 3'd1 && deny[i] && req_we[i])
      |=> word_at(mem_q, $past(req_addr[i*AW +: AW]))
          == $past(word_at(mem_q, req_addr[i*AW +: AW])));

    for (genvar j = i + 1; j < P; j++) begin : g_q
      // R3
      excl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_conc && grant[i] && grant[j] && !req_we[i] && !req_we[j])
        |-> req_addr[i*AW +: AW] != req_addr[j*AW +: AW]);

      // R5
      excl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_conc && grant[i] && grant[j] && req_we[i] && req_we[j])
        |-> req_addr[i*AW +: AW] != req_addr[j*AW +: AW]);
    end
  end
endmodule

bind shmem_resolver smr_checker #(.P(P), .AW(AW), .DW(DW)) u_smr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_conc   (rd_conc),
  .wr_conc   (wr_conc),
  .wr_policy (wr_policy),
  .req_vld   (req_vld),
  .req_we    (req_we),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rd_data   (rd_data),
  .grant     (grant),
  .deny      (deny),
  .mem_q     (mem_q)
);

// File: tb/test_shmem_resolver.sv
module test_shmem_resolver;
  localparam int P  = 4;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                rd_conc = 1'b0, wr_conc = 1'b0;
  logic [2:0]          wr_policy = 3'd0;
  logic [P-1:0]        req_vld = '0, req_we = '0;
  logic [P*AW-1:0]     req_addr = '0;
  logic [P*DW-1:0]     req_wdata = '0;
  logic [P*DW-1:0]     rd_data;
  logic [P-1:0]        grant, deny;
  logic [DEPTH*DW-1:0] mem_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  shmem_resolver #(.P(P), .AW(AW), .DW(DW)) i_shmem_resolver (
    .clk(clk), .rst_n(rst_n), .rd_conc(rd_conc), .wr_conc(wr_conc),
    .wr_policy(wr_policy), .req_vld(req_vld), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .grant(grant), .deny(deny), .mem_q(mem_q)
  );

  function automatic logic [DW-1:0] memw(input int a);
    return mem_q[a*DW +: DW];
  endfunction

  function automatic logic [DW-1:0] rdp(input int p);
    return rd_data[p*DW +: DW];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_req();
    req_vld = '0; req_we = '0; req_addr = '0; req_wdata = '0;
  endtask

  task automatic put(input int p, input bit w, input int a, input int d);
    req_vld[p] = 1'b1;
    req_we[p]  = w;
    req_addr[p*AW +: AW] = AW'(a);
    req_wdata[p*DW +: DW] = DW'(d);
  endtask

  // Requests driven after a falling edge, comb outputs sampled 5 ns later.
  task automatic begin_cycle(input bit rc, input bit wc, input int pol);
    @(negedge clk);
    clear_req();
    rd_conc = rc; wr_conc = wc; wr_policy = 3'(pol);
  endtask

  task automatic commit();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    chk("R1 mem zero", {31'd0, mem_q == '0}, 32'd1);
    chk("R1 grant", 32'(grant), 32'd0);
    chk("R1 deny", 32'(deny), 32'd0);
  endtask

  task automatic t_distinct();
    begin_cycle(0, 0, 0);
    put(0, 1, 1, 'h11); put(1, 1, 2, 'h22); put(2, 0, 1, 0); put(3, 0, 3, 0);
    #5;
    chk("R2 grant", 32'(grant), 32'hF);
    chk("R2 deny", 32'(deny), 32'h0);
    chk("R10 read old", 32'(rdp(2)), 32'h00);
    commit();
    chk("R2 mem1", 32'(memw(1)), 32'h11);
    chk("R2 mem2", 32'(memw(2)), 32'h22);
    begin_cycle(0, 0, 0);
    put(1, 0, 1, 0);
    #5;
    chk("R10 read new", 32'(rdp(1)), 32'h11);
  endtask

  task automatic t_excl_read();
    begin_cycle(0, 0, 0);
    put(0, 0, 1, 0); put(1, 0, 1, 0); put(2, 0, 1, 0); put(3, 0, 2, 0);
    #5;
    chk("R3 grant", 32'(grant), 32'h9);
    chk("R3 deny", 32'(deny), 32'h6);
    chk("R3 winner data", 32'(rdp(0)), 32'h11);
    chk("R3 loser data", 32'(rdp(1)), 32'h00);
    chk("R3 other addr", 32'(rdp(3)), 32'h22);
  endtask

  task automatic t_conc_read();
    begin_cycle(1, 0, 0);
    for (int p = 0; p < P; p++) put(p, 0, 1, 0);
    #5;
    chk("R4 grant", 32'(grant), 32'hF);
    for (int p = 0; p < P; p++) chk("R4 copy", 32'(rdp(p)), 32'h11);
  endtask

  task automatic t_excl_write();
    begin_cycle(0, 0, 0);
    put(1, 1, 4, 'h40); put(3, 1, 4, 'h43); put(2, 0, 4, 0);
    #5;
    chk("R5 grant", 32'(grant), 32'h6);
    chk("R5 deny", 32'(deny), 32'h8);
    chk("R10 read beside write", 32'(rdp(2)), 32'h00);
    chk("R11 idle data", 32'(rdp(0)), 32'h00);
    commit();
    chk("R5 mem4", 32'(memw(4)), 32'h40);
  endtask

  task automatic t_prio();
    begin_cycle(0, 1, 0);
    put(1, 1, 5, 'h51); put(2, 1, 5, 'h52); put(3, 1, 5, 'h53);
    #5;
    chk("R6 grant", 32'(grant), 32'hE);
    commit();
    chk("R6 mem5", 32'(memw(5)), 32'h51);
    begin_cycle(0, 1, 6);
    put(2, 1, 5, 'h62); put(3, 1, 5, 'h63);
    commit();
    chk("R6 code6 as prio", 32'(memw(5)), 32'h62);
  endtask

  task automatic t_common();
    begin_cycle(0, 1, 1);
    put(0, 1, 6, 'h66); put(1, 1, 6, 'h66); put(2, 1, 6, 'h66);
    #5;
    chk("R7 equal grant", 32'(grant), 32'h7);
    commit();
    chk("R7 equal stored", 32'(memw(6)), 32'h66);
    begin_cycle(0, 1, 1);
    put(0, 1, 6, 'h70); put(3, 1, 6, 'h71); put(1, 1, 7, 'h77);
    #5;
    chk("R7 mismatch deny", 32'(deny), 32'h9);
    chk("R7 lone grant", 32'(grant), 32'h2);
    commit();
    chk("R7 word held", 32'(memw(6)), 32'h66);
    chk("R7 lone stored", 32'(memw(7)), 32'h77);
  endtask

  task automatic t_maxmin();
    begin_cycle(0, 1, 2);
    put(0, 1, 3, 'h10); put(1, 1, 3, 'h90); put(2, 1, 3, 'h30); put(3, 1, 3, 'h05);
    #5;
    chk("R8 grant", 32'(grant), 32'hF);
    commit();
    chk("R8 max", 32'(memw(3)), 32'h90);
    begin_cycle(0, 1, 3);
    put(0, 1, 3, 'h10); put(1, 1, 3, 'h90); put(2, 1, 3, 'h30); put(3, 1, 3, 'h05);
    commit();
    chk("R8 min", 32'(memw(3)), 32'h05);
  endtask

  task automatic t_sum();
    begin_cycle(0, 1, 4);
    put(0, 1, 0, 'h80); put(2, 1, 0, 'h90); put(3, 1, 0, 'h10);
    commit();
    chk("R9 sum wraps", 32'(memw(0)), 32'h20);
  endtask

  task automatic t_idle();
    begin_cycle(0, 0, 0);
    put(2, 0, 4, 0);
    #5;
    chk("R11 grant", 32'(grant), 32'h4);
    chk("R11 deny", 32'(deny), 32'h0);
    chk("R11 idle p0", 32'(rdp(0)), 32'h00);
    chk("R11 idle p3", 32'(rdp(3)), 32'h00);
    chk("R11 reader", 32'(rdp(2)), 32'h40);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #50;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    t_reset();
    t_distinct();
    t_excl_read();
    t_conc_read();
    t_excl_write();
    t_prio();
    t_common();
    t_maxmin();
    t_sum();
    t_idle();
    begin_cycle(0, 0, 0);
    #5;
    finish_run();
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule